// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block divides two 64-bit integers for a processor execute stage. One request is accepted when `req_valid` is high while `busy` is low. `req_op` chooses signedness, operand size (doubleword or word), and the kind of operation: plain quotient, extended quotient, or remainder. The operands are turned into magnitudes. A radix-2 restoring loop runs for a fixed 64 steps on a 128-by-64-bit shift pair. A result stage then restores the sign, checks that the quotient fits, and sizes the value to 64 bits.

Any case the architecture leaves undefined gives a result of all zeros. These cases are a zero divisor, a quotient that does not fit the target width, and an extended dividend too large for the divisor. The response carries the 64-bit result together with a 32-bit condition-register word. The word holds a four-bit comparison field, found by comparing the final 64-bit result against zero as a signed value. The response is a one-cycle `rsp_valid` pulse. `rsp_data` and `rsp_cond` keep their value until the next response.

Top module: `int_div_unit`

## Requirements
- R1: After an accepted request, `rsp_valid` pulses high for exactly one cycle, no more than 67 clock cycles later. It never rises without an accepted request.
- R2: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the response cycle. A `req_valid` seen while `busy` is high is ignored, leaving no trace in any later response.
- R3: `req_op` is {kind[1:0], word, signed}. Kind 0 is a plain divide, 1 an extended divide, 2 a remainder. Word forms use `req_b[31:0]` as the divisor. A zero divisor gives a zero result for every divide and remainder form.
- R4: A signed plain divide truncates toward zero. If the quotient does not fit the width, the result is zero. Doubleword: 0x8000000000000000 by all-ones. Word: a low word of 0x80000000 divided by 0xFFFFFFFF. A word quotient is returned zero-extended.
- R5: An unsigned plain divide returns `req_a / req_b`. The word form divides `req_a[31:0]` by `req_b[31:0]` and returns the quotient zero-extended; upper operand bits have no effect.
- R6: The signed extended doubleword divide treats `req_a` followed by 64 zero bits as a 128-bit dividend. It returns the quotient only when the quotient fits in a signed 64-bit value, and zero otherwise.
- R7: The unsigned extended doubleword divide returns the low 64 bits of ({`req_a`, 64'b0} / `req_b`) when `req_b > req_a`, and zero otherwise.
- R8: Extended word forms divide {`req_a[63:32]`, 32'b0} by `req_b[31:0]`. The unsigned form is valid only when `req_b[31:0] > req_a[63:32]`. The signed form is valid only when the quotient fits in 32 signed bits. A valid word quotient is zero-extended, and an invalid one gives zero.
- R9: Remainders truncate, so the remainder takes the sign of the dividend. The signed word remainder is sign-extended to 64 bits and the unsigned word remainder is zero-extended.
- R10: `rsp_cond[31:28]` is {LT, GT, EQ, 0}, from a signed comparison of the 64-bit result with zero. `rsp_cond[27:0]` is zero.
- R11: Kind 3 (ops 12 to 15) is reserved and returns a zero result with EQ set.
- R12: While reset is held and after it is released, `busy` and `rsp_valid` are low and `rsp_data` and `rsp_cond` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 4 | Operation select {kind, word, signed} |
| req_a | input | 64 | Dividend operand |
| req_b | input | 64 | Divisor operand |
| busy | output | 1 | A division is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Sized result |
| rsp_cond | output | 32 | Condition-register write value |

## Verification
The assertions assume that a request is always a single-cycle strobe, and that operands matter only in the accepting cycle. The latency checks count from the cycle in which `busy` was low and `req_valid` high. The stimulus drives each request for one cycle between clock edges and drops `req_valid` afterwards. The one deliberate exception is a request issued mid-division, used to show that it is dropped. Operands cover sign combinations, both overflow corners, zero divisors with non-zero upper halves, and pseudo-random values for every opcode.

// File: rtl/int_div_pkg.sv
package int_div_pkg;

  localparam int OP_W   = 4;
  localparam int COND_W = 32;
  localparam int FLD_LSB = 28;

  typedef enum logic [1:0] {
    K_DIV = 2'b00,
    K_EXT = 2'b01,
    K_REM = 2'b10,
    K_RSV = 2'b11
  } div_kind_e;

  typedef struct packed {
    div_kind_e kind;
    logic      word;
    logic      sgn;
    logic      quo_neg;
    logic      rem_neg;
    logic      bad;
  } div_ctl_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import int_div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] ra,
  input  logic [XLEN-1:0] rb,
  output logic [XLEN-1:0] num_hi,
  output logic [XLEN-1:0] num_lo,
  output logic [XLEN-1:0] den,
  output div_ctl_t        ctl
);

  localparam int HALF = XLEN / 2;

  div_kind_e       kind;
  logic            word;
  logic            sgn;
  logic [XLEN-1:0] a_raw;
  logic [XLEN-1:0] b_raw;
  logic            a_msb;
  logic            b_msb;
  logic            neg_a;
  logic            neg_b;
  logic [XLEN-1:0] mag_a;
  logic [XLEN-1:0] mag_b;

  function automatic logic [XLEN-1:0] magnitude(logic [XLEN-1:0] v, logic neg, logic half);
    logic [HALF-1:0] lo_n;
    logic [XLEN-1:0] full_n;
    lo_n   = -v[HALF-1:0];
    full_n = -v;
    if (!neg)      return v;
    else if (half) return {{HALF{1'b0}}, lo_n};
    else           return full_n;
  endfunction

  always_comb begin
    kind = div_kind_e'(op[3:2]);
    word = op[1];
    sgn  = op[0];
    if (word) begin
      if (kind == K_EXT) begin
        a_raw = {{HALF{1'b0}}, ra[XLEN-1:HALF]};
        a_msb = ra[XLEN-1];
      end else begin
        a_raw = {{HALF{1'b0}}, ra[HALF-1:0]};
        a_msb = ra[HALF-1];
      end
      b_raw = {{HALF{1'b0}}, rb[HALF-1:0]};
      b_msb = rb[HALF-1];
    end else begin
      a_raw = ra;
      a_msb = ra[XLEN-1];
      b_raw = rb;
      b_msb = rb[XLEN-1];
    end
    neg_a = sgn & a_msb;
    neg_b = sgn & b_msb;
    mag_a = magnitude(a_raw, neg_a, word);
    mag_b = magnitude(b_raw, neg_b, word);

    num_hi = '0;
    num_lo = mag_a;
    if (kind == K_EXT) begin
      if (word) num_lo = mag_a << HALF;
      else begin
        num_hi = mag_a;
        num_lo = '0;
      end
    end
    den = mag_b;

    ctl.kind    = kind;
    ctl.word    = word;
    ctl.sgn     = sgn;
    ctl.quo_neg = neg_a ^ neg_b;
    ctl.rem_neg = neg_a;
    // a zero divisor also satisfies this compare
    ctl.bad     = (num_hi >= mag_b) || (kind == K_RSV);
  end

endmodule

// File: rtl/div_iter_core.sv
module div_iter_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] num_hi,
  input  logic [XLEN-1:0] num_lo,
  input  logic [XLEN-1:0] den,
  output logic            running,
  output logic            done,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);

  localparam int CNT_W = $clog2(XLEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XLEN - 1);

  logic [XLEN-1:0]  rem_q, rem_d;
  logic [XLEN-1:0]  quo_q, quo_d;
  logic [XLEN-1:0]  den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [XLEN:0]    shifted;
  logic [XLEN:0]    trial;
  logic             qbit;

  always_comb begin
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    shifted = {rem_q, quo_q[XLEN-1]};
    trial   = shifted - {1'b0, den_q};
    qbit    = ~trial[XLEN];
    done_d  = run_q && (cnt_q == LAST);
    if (start) begin
      rem_d = num_hi;
      quo_d = num_lo;
      den_d = den;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = qbit ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      quo_d = {quo_q[XLEN-2:0], qbit};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign running = run_q;
  assign done    = done_q;
  assign quo     = quo_q;
  assign rem     = rem_q;

  // loop keeps going until the last step, then hands over
  assert_run_continues_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != LAST && !start) |=> run_q);
  assert_done_after_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !start);

endmodule

// File: rtl/div_result_fmt.sv
module div_result_fmt
  import int_div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  div_ctl_t          ctl,
  input  logic [XLEN-1:0]   quo,
  input  logic [XLEN-1:0]   rem,
  output logic [XLEN-1:0]   res,
  output logic [COND_W-1:0] cond
);

  localparam int HALF = XLEN / 2;

  logic            hi_clear;
  logic            top_bit;
  logic            rest_zero;
  logic            fits;
  logic            ok;
  logic [XLEN-1:0] q_signed;
  logic [XLEN-1:0] r_signed;
  logic [XLEN-1:0] raw;
  logic            lt;
  logic            eq;

  always_comb begin
    hi_clear  = ctl.word ? (quo[XLEN-1:HALF] == '0) : 1'b1;
    top_bit   = ctl.word ? quo[HALF-1] : quo[XLEN-1];
    rest_zero = ctl.word ? (quo[HALF-2:0] == '0) : (quo[XLEN-2:0] == '0);
    // negative quotients may reach one step further than positive ones
    fits      = hi_clear && (!ctl.sgn || !top_bit || (ctl.quo_neg && rest_zero));
    q_signed  = ctl.quo_neg ? -quo : quo;
    r_signed  = ctl.rem_neg ? -rem : rem;
    if (ctl.kind == K_REM) begin
      ok = 1'b1;
      if (!ctl.word)    raw = r_signed;
      else if (ctl.sgn) raw = {{HALF{r_signed[HALF-1]}}, r_signed[HALF-1:0]};
      else              raw = {{HALF{1'b0}}, r_signed[HALF-1:0]};
    end else begin
      ok  = fits;
      raw = ctl.word ? {{HALF{1'b0}}, q_signed[HALF-1:0]} : q_signed;
    end
    res  = (ok && !ctl.bad) ? raw : '0;
    lt   = res[XLEN-1];
    eq   = (res == '0);
    cond = '0;
    cond[FLD_LSB+3] = lt;
    cond[FLD_LSB+2] = !lt && !eq;
    cond[FLD_LSB+1] = eq;
    cond[FLD_LSB]   = 1'b0;
  end

endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import int_div_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int LAT_MAX = 67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [XLEN-1:0]   req_a,
  input  logic [XLEN-1:0]   req_b,
  output logic              busy,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_data,
  output logic [COND_W-1:0] rsp_cond
);

  localparam int LAT_W = $clog2(LAT_MAX + 2) + 1;

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic              start;
  logic [XLEN-1:0]   p_hi, p_lo, p_den;
  div_ctl_t          p_ctl;
  div_ctl_t          ctl_q, ctl_d;
  logic              core_run;
  logic              core_done;
  logic [XLEN-1:0]   core_quo, core_rem;
  logic [XLEN-1:0]   fmt_res;
  logic [COND_W-1:0] fmt_cond;
  logic              vld_q, vld_d;
  logic [XLEN-1:0]   data_q, data_d;
  logic [COND_W-1:0] cond_q, cond_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign busy  = core_run | core_done;
  assign start = req_valid & ~busy & rst_sync_n;

  div_operand_prep #(.XLEN(XLEN)) u_prep (
    .op(req_op), .ra(req_a), .rb(req_b),
    .num_hi(p_hi), .num_lo(p_lo), .den(p_den), .ctl(p_ctl)
  );

  div_iter_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .num_hi(p_hi), .num_lo(p_lo), .den(p_den),
    .running(core_run), .done(core_done), .quo(core_quo), .rem(core_rem)
  );

  div_result_fmt #(.XLEN(XLEN)) u_fmt (
    .ctl(ctl_q), .quo(core_quo), .rem(core_rem),
    .res(fmt_res), .cond(fmt_cond)
  );

  always_comb begin
    ctl_d  = start ? p_ctl : ctl_q;
    vld_d  = core_done;
    data_d = core_done ? fmt_res : data_q;
    cond_d = core_done ? fmt_cond : cond_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      cond_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      vld_q  <= vld_d;
      data_q <= data_d;
      cond_q <= cond_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
  assign rsp_cond  = cond_q;

  // cycles since the last accepted request, checker support only
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)       lat_q <= '0;
    else if (start)        lat_q <= LAT_W'(1);
    else if (vld_q)        lat_q <= '0;
    else if (lat_q != '0)  lat_q <= lat_q + 1'b1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (lat_q != '0 && lat_q <= LAT_W'(LAT_MAX)));
  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_excl_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy && rsp_valid));
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> busy);
  assert_cond_shape_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_cond[FLD_LSB-1:0] == '0 && !rsp_cond[FLD_LSB]
                   && $onehot(rsp_cond[COND_W-1:FLD_LSB+1])));
  assert_cond_eq_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_cond[FLD_LSB+1] == (rsp_data == '0)));
  assert_cond_lt_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_cond[FLD_LSB+3] == rsp_data[XLEN-1]));

endmodule

// File: tb/test_int_div_unit.sv
module test_int_div_unit;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [63:0] req_a;
  logic [63:0] req_b;
  logic        busy;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic [31:0] rsp_cond;

  int n_checks = 0;
  int n_fails  = 0;
  bit done_flag = 0;

  // model state
  bit          pending = 0;
  bit          arm = 0;
  bit          got = 0;
  int          lat = 0;
  int          rsp_lat = 0;
  logic [63:0] got_data;
  logic [31:0] got_cond;

  int_div_unit i_int_div_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_a(req_a), .req_b(req_b), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_cond(rsp_cond)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_cond(logic [63:0] r);
    logic lt, eq;
    lt = r[63];
    eq = (r == 64'h0);
    return {lt, !lt && !eq, eq, 1'b0, 28'h0};
  endfunction

  function automatic logic [63:0] ref_calc(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic signed [127:0] n, d, q;
    logic [127:0]        un;
    logic [31:0]         a32, b32, ah32;
    logic                fit;
    a32  = a[31:0];
    b32  = b[31:0];
    ah32 = a[63:32];
    case (op)
      4'd0: return (b == 0) ? 64'h0 : a / b;
      4'd1: begin
        if (b == 0) return 64'h0;
        n = {{64{a[63]}}, a}; d = {{64{b[63]}}, b}; q = n / d;
        fit = (&q[127:63]) | ~(|q[127:63]);
        return fit ? q[63:0] : 64'h0;
      end
      4'd2: return (b32 == 0) ? 64'h0 : {32'h0, a32 / b32};
      4'd3: begin
        if (b32 == 0) return 64'h0;
        n = {{96{a32[31]}}, a32}; d = {{96{b32[31]}}, b32}; q = n / d;
        fit = (&q[127:31]) | ~(|q[127:31]);
        return fit ? {32'h0, q[31:0]} : 64'h0;
      end
      4'd4: begin
        if (!(b > a)) return 64'h0;
        un = {a, 64'h0} / {64'h0, b};
        return un[63:0];
      end
      4'd5: begin
        if (b == 0) return 64'h0;
        n = {a, 64'h0}; d = {{64{b[63]}}, b}; q = n / d;
        fit = (&q[127:63]) | ~(|q[127:63]);
        return fit ? q[63:0] : 64'h0;
      end
      4'd6: begin
        if (!(b32 > ah32)) return 64'h0;
        un = {64'h0, ah32, 32'h0} / {96'h0, b32};
        return {32'h0, un[31:0]};
      end
      4'd7: begin
        if (b32 == 0) return 64'h0;
        n = {{64{ah32[31]}}, ah32, 32'h0}; d = {{96{b32[31]}}, b32}; q = n / d;
        fit = (&q[127:31]) | ~(|q[127:31]);
        return fit ? {32'h0, q[31:0]} : 64'h0;
      end
      4'd8: return (b == 0) ? 64'h0 : a % b;
      4'd9: begin
        if (b == 0) return 64'h0;
        n = {{64{a[63]}}, a}; d = {{64{b[63]}}, b}; q = n % d;
        return q[63:0];
      end
      4'd10: return (b32 == 0) ? 64'h0 : {32'h0, a32 % b32};
      4'd11: begin
        if (b32 == 0) return 64'h0;
        n = {{96{a32[31]}}, a32}; d = {{96{b32[31]}}, b32}; q = n % d;
        return {{32{q[31]}}, q[31:0]};
      end
      default: return 64'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0, 4'd2: return "R5";
      4'd1, 4'd3: return "R4";
      4'd4:       return "R7";
      4'd5:       return "R6";
      4'd6, 4'd7: return "R8";
      4'd8, 4'd9, 4'd10, 4'd11: return "R9";
      default:    return "R11";
    endcase
  endfunction

  // one clock: sample at the falling edge, update the model, compare
  task automatic tick();
    @(negedge clk);
    if (arm) begin
      pending = 1;
      arm = 0;
      lat = 0;
    end
    if (pending) lat++;
    if (rsp_valid) begin
      if (!pending) begin
        n_checks++;
        n_fails++;
        $display("FAIL R1: actual rsp_valid 1 expected 0 (no request outstanding)");
      end
      got = 1;
      got_data = rsp_data;
      got_cond = rsp_cond;
      rsp_lat = lat;
      pending = 0;
    end
    n_checks++;
    if (busy !== pending) begin
      n_fails++;
      $display("FAIL R2: busy actual %0b expected %0b", busy, pending);
    end
  endtask

  task automatic wait_rsp();
    for (int i = 0; i < 80 && !got; i++) tick();
    n_checks++;
    if (!got) begin
      n_fails++;
      $display("FAIL R1: actual no response expected response within 67 cycles");
    end else if (rsp_lat > 67) begin
      n_fails++;
      $display("FAIL R1: latency actual %0d expected <= 67", rsp_lat);
    end
  endtask

  task automatic do_case(logic [3:0] op, logic [63:0] a, logic [63:0] b, string req);
    logic [63:0] exp;
    exp = ref_calc(op, a, b);
    req_op = op; req_a = a; req_b = b; req_valid = 1'b1;
    arm = 1; got = 0;
    tick();
    req_valid = 1'b0;
    req_a = ~a; req_b = ~b;
    wait_rsp();
    if (got) begin
      check64(req, got_data, exp);
      check64("R10", {32'h0, got_cond}, {32'h0, ref_cond(exp)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report_end();
    end
  end

  initial begin
    logic [63:0] s;
    logic [63:0] ra_x, rb_x;
    req_valid = 1'b0; req_op = '0; req_a = '0; req_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state while held
    check64("R12", {60'h0, busy, rsp_valid, 2'b0}, 64'h0);
    check64("R12", rsp_data, 64'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    check64("R12", {32'h0, rsp_cond}, 64'h0);
    check64("R12", {62'h0, busy, rsp_valid}, 64'h0);

    // R5 unsigned plain
    do_case(4'd0, 64'd100, 64'd7, "R5");
    do_case(4'd0, 64'hFFFFFFFFFFFFFFFF, 64'd1, "R5");
    do_case(4'd2, 64'hFFFFFFFF00000064, 64'hABCD000000000007, "R5");
    // R4 signed plain and overflow corners
    do_case(4'd1, -64'sd100, 64'd7, "R4");
    do_case(4'd1, 64'd100, -64'sd7, "R4");
    do_case(4'd1, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, "R4");
    do_case(4'd3, 64'hFFFFFFFF80000000, 64'hFFFFFFFFFFFFFFFF, "R4");
    do_case(4'd3, 64'h00000000FFFFFF9C, 64'd7, "R4");
    // R3 zero divisor for every form (word forms: low word zero)
    for (int op = 0; op < 12; op++)
      do_case(4'(op), 64'h123456789ABCDEF0, 64'hFFFFFFFF00000000 & {64{op[1]}}, "R3");
    // R6 signed extended doubleword
    do_case(4'd5, 64'd1, 64'd3, "R6");
    do_case(4'd5, 64'd1, 64'd2, "R6");
    do_case(4'd5, 64'hFFFFFFFFFFFFFFFF, 64'd2, "R6");
    do_case(4'd5, 64'd5, 64'd3, "R6");
    // R7 unsigned extended doubleword
    do_case(4'd4, 64'd1, 64'd3, "R7");
    do_case(4'd4, 64'd3, 64'd3, "R7");
    do_case(4'd4, 64'd1, 64'd2, "R7");
    // R8 extended word
    do_case(4'd6, 64'h00000001_DEADBEEF, 64'd3, "R8");
    do_case(4'd6, 64'h00000003_00000000, 64'd3, "R8");
    do_case(4'd7, 64'hFFFFFFFF_00000000, 64'd2, "R8");
    do_case(4'd7, 64'h00000001_00000000, 64'd2, "R8");
    do_case(4'd7, 64'h00000001_00000000, 64'h00000000FFFFFFFD, "R8");
    // R9 remainders
    do_case(4'd9, -64'sd7, 64'd3, "R9");
    do_case(4'd9, 64'd7, -64'sd3, "R9");
    do_case(4'd9, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, "R9");
    do_case(4'd8, 64'hFFFFFFFFFFFFFFFF, 64'd10, "R9");
    do_case(4'd11, 64'h00000000FFFFFFF9, 64'd3, "R9");
    do_case(4'd10, 64'h55555555FFFFFFF9, 64'd3, "R9");
    // R11 reserved kinds
    for (int op = 12; op < 16; op++)
      do_case(4'(op), 64'd100, 64'd7, "R11");

    // R2 request during a division is dropped
    req_op = 4'd0; req_a = 64'd1000; req_b = 64'd10; req_valid = 1'b1;
    arm = 1; got = 0;
    tick();
    req_valid = 1'b0;
    repeat (3) tick();
    req_op = 4'd0; req_a = 64'd999; req_b = 64'd1; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    wait_rsp();
    check64("R2", got_data, 64'd100);
    got = 0;
    repeat (80) tick();
    check64("R2", {63'h0, got}, 64'h0);
    check64("R2", rsp_data, 64'd100);

    // pseudo-random sweep over all opcodes
    s = 64'h9E3779B97F4A7C15;
    for (int k = 0; k < 48; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 7); ra_x = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); rb_x = s >> (k % 40);
      do_case(4'(k % 12), ra_x, rb_x, tag_of(4'(k % 12)));
    end

    done_flag = 1;
    report_end();
  end

endmodule